// File: doc/BRIEF.md
# EDO DRAM Cycle-Type Decoder

This block sits on the device side of an asynchronous DRAM strobe bus and watches the row strobe, one column strobe per byte lane, the write strobe and the output-enable strobe. It samples them on a fast system clock and names each memory cycle from the order and levels of those strobes. It also reports which byte lanes took part in the cycle and, for each lane, whether the device would be driving read data at that moment. A DRAM behavioural model can use these outputs to decide when to write its array and when to drive its data pins. A protocol checker can use them to count cycle types and catch bad strobe orderings.

All strobes are active low. Every input passes through one capture register, and edges are found by comparing that capture with the one before it. A level change applied before clock edge k therefore shows on the outputs just after edge k+1. The column strobes are merged by OR into a single "column active" condition, which fixes the cycle mode and marks column accesses. Each lane still keeps its own output-drive state and write-mode record. A lane whose write mode in an access differs from that of another lane in the same access sets a sticky error.

Top module: `edo_cycle_decoder`

## Requirements
- R1: While rst_ni is low and on the first clocks after its release, cyc_valid_o=0, cyc_type_o=0 (standby), lane_o=0, page_o=0, dout_en_o=0 and err_o=0.
- R2: When the row strobe rises at the end of a cycle, cyc_valid_o is high for exactly one clock, 2 clock edges after the rise is applied. In that clock cyc_type_o carries the code: 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 column-before-row refresh, 7 read with output disabled. At every other time cyc_type_o is 0 (standby).
- R3: If any column strobe is low in the sample where the row strobe falls, the cycle is a column-before-row refresh (6), and lane_o is 0 with the pulse.
- R4: If the row strobe falls with every column strobe high and no column strobe falls before it rises again, the cycle is a row-only refresh (5) with lane_o=0.
- R5: If the write strobe is low in the sample of the first merged column fall, the cycle is an early write (2). No lane drives data during an access that was opened that way.
- R6: If the write strobe falls while some column strobe is low and the access was not an early write, the cycle is a write. It is read-modify-write (4) if a lane drove data earlier in the cycle, otherwise delayed write (3).
- R7: A cycle with column accesses and no write is a read (1) if the output-enable strobe was seen low with a column strobe low and the write strobe high; otherwise it is an output-disabled read (7).
- R8: With the pulse, lane_o bit i is 1 when lane i's column strobe fell during the cycle (bit 1 upper lane, bit 0 lower lane).
- R9: dout_en_o bit i turns on when all of these hold: the row strobe is low in a normal cycle, the lane's column strobe is low, the write strobe is high, output enable is low, and the access is not an early write. It then stays on until output enable rises, or the write strobe goes low, or both the row strobe and that lane's column strobe are high. The output therefore survives a row strobe toggle while the column strobe is held low.
- R10: page_o is 1 with the pulse when the merged column strobe fell more than once while the row strobe was low.
- R11: err_o goes high, and stays high until reset, when a lane's column strobe falls inside an access already opened by another lane and the write strobe level differs from the one recorded for that other lane.
- R12: A second lane falling after the first, within the same merged column-low period, does not start a new access and does not set page_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | LANES | Column strobe per byte lane, active low, bit 1 upper |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable strobe, active low |
| cyc_valid_o | output | 1 | One-clock pulse at the end of a cycle |
| cyc_type_o | output | 3 | Cycle type code, 0 outside the pulse |
| lane_o | output | LANES | Lanes that took part, valid with the pulse |
| page_o | output | 1 | Multi-access page cycle, valid with the pulse |
| dout_en_o | output | LANES | Per-lane data output drive |
| err_o | output | 1 | Sticky illegal lane mode flag |

## Verification
The bench targets a hidden refresh, where the column strobes stay low across a row strobe toggle. A decoder that drops the output on the row rise, or that does not see the column-low row fall as a refresh, shows a wrong dout_en_o or type at once. Staggered lane falls test the merged column view: a design that counts every lane edge as an access would report a page cycle. The difference between read-modify-write and delayed write depends only on whether data was driven before the write strobe fell, and an early write must never drive data. The mixed-mode lane case must set the sticky error, and no earlier legal cycle may set it.

// File: rtl/edo_dec_pkg.sv
package edo_dec_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_READ  = 3'd1,
    CYC_EWR   = 3'd2,
    CYC_DWR   = 3'd3,
    CYC_RMW   = 3'd4,
    CYC_ROR   = 3'd5,
    CYC_CBR   = 3'd6,
    CYC_RDOFF = 3'd7
  } cyc_e;
endpackage

// File: rtl/edo_strobe_sampler.sv
module edo_strobe_sampler #(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_n_i,
  input  logic [LANES-1:0] cas_n_i,
  input  logic             we_n_i,
  input  logic             oe_n_i,
  output logic             ras_lo_o,
  output logic             ras_fall_o,
  output logic             ras_rise_o,
  output logic [LANES-1:0] cas_lo_o,
  output logic [LANES-1:0] cas_fall_o,
  output logic             any_cas_lo_o,
  output logic             any_cas_fall_o,
  output logic             we_lo_o,
  output logic             we_fall_o,
  output logic             oe_lo_o
);
  localparam int W = LANES + 3;

  logic [W-1:0] cur_q, prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '1;
      prv_q <= '1;
    end else begin
      cur_q <= {ras_n_i, we_n_i, oe_n_i, cas_n_i};
      prv_q <= cur_q;
    end
  end

  logic [LANES-1:0] cas_c, cas_p;
  assign cas_c = cur_q[LANES-1:0];
  assign cas_p = prv_q[LANES-1:0];

  assign ras_lo_o       = ~cur_q[W-1];
  assign ras_fall_o     =  prv_q[W-1] & ~cur_q[W-1];
  assign ras_rise_o     = ~prv_q[W-1] &  cur_q[W-1];
  assign we_lo_o        = ~cur_q[W-2];
  assign we_fall_o      =  prv_q[W-2] & ~cur_q[W-2];
  assign oe_lo_o        = ~cur_q[W-3];
  assign cas_lo_o       = ~cas_c;
  assign cas_fall_o     =  cas_p & ~cas_c;
  assign any_cas_lo_o   = ~&cas_c;
  assign any_cas_fall_o = (&cas_p) & ~(&cas_c);
endmodule

// File: rtl/edo_cycle_tracker.sv
module edo_cycle_tracker
  import edo_dec_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_lo_i,
  input  logic             ras_fall_i,
  input  logic             ras_rise_i,
  input  logic [LANES-1:0] cas_fall_i,
  input  logic             any_cas_lo_i,
  input  logic             any_cas_fall_i,
  input  logic             we_lo_i,
  input  logic             we_fall_i,
  input  logic             oe_lo_i,
  output logic             rd_ok_o,
  output logic             cyc_valid_o,
  output cyc_e             cyc_type_o,
  output logic [LANES-1:0] lane_o,
  output logic             page_o,
  output logic             err_o
);
  logic in_cyc_q, cbr_q, seen_q, first_early_q, acc_early_q;
  logic wr_late_q, rd_q, page_q, err_q;
  logic [LANES-1:0] lane_seen_q, lane_acc_q, lane_mode_q;

  logic acc_early_eff, normal, mism, end_cyc;
  cyc_e type_now;

  assign acc_early_eff = any_cas_fall_i ? we_lo_i : acc_early_q;
  assign normal  = in_cyc_q & ras_lo_i & ~cbr_q & ~ras_fall_i;
  assign rd_ok_o = in_cyc_q & ~cbr_q & ~acc_early_eff;
  assign end_cyc = ras_rise_i & in_cyc_q;

  // a lane joining an open access with a different write level
  always_comb begin
    mism = 1'b0;
    for (int i = 0; i < LANES; i++)
      for (int j = 0; j < LANES; j++)
        if (i != j && cas_fall_i[i] && !any_cas_fall_i && lane_acc_q[j] &&
            (lane_mode_q[j] != we_lo_i))
          mism = 1'b1;
  end

  always_comb begin
    if (cbr_q)                    type_now = CYC_CBR;
    else if (!seen_q)             type_now = CYC_ROR;
    else if (first_early_q)       type_now = CYC_EWR;
    else if (wr_late_q && rd_q)   type_now = CYC_RMW;
    else if (wr_late_q)           type_now = CYC_DWR;
    else if (rd_q)                type_now = CYC_READ;
    else                          type_now = CYC_RDOFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cyc_q <= 1'b0; cbr_q <= 1'b0; seen_q <= 1'b0;
      first_early_q <= 1'b0; acc_early_q <= 1'b0;
      wr_late_q <= 1'b0; rd_q <= 1'b0; page_q <= 1'b0; err_q <= 1'b0;
      lane_seen_q <= '0; lane_acc_q <= '0; lane_mode_q <= '0;
    end else if (ras_fall_i) begin
      in_cyc_q <= 1'b1;
      cbr_q <= any_cas_lo_i;
      seen_q <= 1'b0; first_early_q <= 1'b0; acc_early_q <= 1'b0;
      wr_late_q <= 1'b0; rd_q <= 1'b0; page_q <= 1'b0;
      lane_seen_q <= '0; lane_acc_q <= '0;
    end else if (normal) begin
      if (any_cas_fall_i) begin
        seen_q <= 1'b1;
        acc_early_q <= we_lo_i;
        if (seen_q) page_q <= 1'b1;
        else        first_early_q <= we_lo_i;
      end
      lane_acc_q  <= any_cas_fall_i ? cas_fall_i : (lane_acc_q | cas_fall_i);
      lane_seen_q <= lane_seen_q | cas_fall_i;
      for (int i = 0; i < LANES; i++)
        if (cas_fall_i[i]) lane_mode_q[i] <= we_lo_i;
      if (we_fall_i && any_cas_lo_i && !acc_early_eff) wr_late_q <= 1'b1;
      if (any_cas_lo_i && oe_lo_i && !we_lo_i && !acc_early_eff) rd_q <= 1'b1;
      if (mism) err_q <= 1'b1;
    end else if (end_cyc) begin
      in_cyc_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_valid_o <= 1'b0;
      cyc_type_o  <= CYC_IDLE;
      lane_o      <= '0;
      page_o      <= 1'b0;
    end else begin
      cyc_valid_o <= end_cyc;
      cyc_type_o  <= end_cyc ? type_now : CYC_IDLE;
      lane_o      <= end_cyc ? lane_seen_q : '0;
      page_o      <= end_cyc & page_q;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/edo_lane_drive.sv
module edo_lane_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_ok_i,
  input  logic ras_lo_i,
  input  logic cas_lo_i,
  input  logic we_lo_i,
  input  logic oe_lo_i,
  output logic drive_o
);
  logic on_c, hold_c;

  assign on_c   = rd_ok_i & ras_lo_i & cas_lo_i & ~we_lo_i & oe_lo_i;
  // output lasts until the later of row and column rising
  assign hold_c = drive_o & oe_lo_i & ~we_lo_i & (ras_lo_i | cas_lo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_o <= 1'b0;
    else         drive_o <= on_c | hold_c;
  end
endmodule

// File: rtl/edo_cycle_decoder.sv
module edo_cycle_decoder
  import edo_dec_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_n_i,
  input  logic [LANES-1:0] cas_n_i,
  input  logic             we_n_i,
  input  logic             oe_n_i,
  output logic             cyc_valid_o,
  output logic [2:0]       cyc_type_o,
  output logic [LANES-1:0] lane_o,
  output logic             page_o,
  output logic [LANES-1:0] dout_en_o,
  output logic             err_o
);
  logic             ras_lo, ras_fall, ras_rise, any_cas_lo, any_cas_fall;
  logic             we_lo, we_fall, oe_lo, rd_ok;
  logic [LANES-1:0] cas_lo, cas_fall;
  cyc_e             cyc_type;

  edo_strobe_sampler #(.LANES(LANES)) u_smp (
    .clk_i, .rst_ni, .ras_n_i, .cas_n_i, .we_n_i, .oe_n_i,
    .ras_lo_o(ras_lo), .ras_fall_o(ras_fall), .ras_rise_o(ras_rise),
    .cas_lo_o(cas_lo), .cas_fall_o(cas_fall),
    .any_cas_lo_o(any_cas_lo), .any_cas_fall_o(any_cas_fall),
    .we_lo_o(we_lo), .we_fall_o(we_fall), .oe_lo_o(oe_lo)
  );

  edo_cycle_tracker #(.LANES(LANES)) u_trk (
    .clk_i, .rst_ni,
    .ras_lo_i(ras_lo), .ras_fall_i(ras_fall), .ras_rise_i(ras_rise),
    .cas_fall_i(cas_fall), .any_cas_lo_i(any_cas_lo),
    .any_cas_fall_i(any_cas_fall), .we_lo_i(we_lo), .we_fall_i(we_fall),
    .oe_lo_i(oe_lo), .rd_ok_o(rd_ok), .cyc_valid_o(cyc_valid_o),
    .cyc_type_o(cyc_type), .lane_o(lane_o), .page_o(page_o), .err_o(err_o)
  );

  assign cyc_type_o = cyc_type;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    edo_lane_drive u_drv (
      .clk_i, .rst_ni, .rd_ok_i(rd_ok), .ras_lo_i(ras_lo),
      .cas_lo_i(cas_lo[g]), .we_lo_i(we_lo), .oe_lo_i(oe_lo),
      .drive_o(dout_en_o[g])
    );
  end
endmodule

// File: rtl/edo_cycle_decoder_chk.sv
module edo_cycle_decoder_chk #(
  parameter int LANES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ras_n_i,
  input logic [LANES-1:0] cas_n_i,
  input logic             we_n_i,
  input logic             oe_n_i,
  input logic             cyc_valid_o,
  input logic [2:0]       cyc_type_o,
  input logic [LANES-1:0] lane_o,
  input logic             page_o,
  input logic [LANES-1:0] dout_en_o,
  input logic             err_o
);
  // R2
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o |=> !cyc_valid_o);
  // R2
  idle_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_valid_o |-> cyc_type_o == 3'd0);
  // R2
  pulse_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o |-> $past(ras_n_i, 2) && !$past(ras_n_i, 3));
  // R3
  cbr_no_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_o && cyc_type_o == 3'd6) |-> lane_o == '0);
  // R4
  ror_no_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_o && cyc_type_o == 3'd5) |-> lane_o == '0);
  // R9
  drive_needs_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dout_en_o) |-> !$past(oe_n_i, 2) && $past(we_n_i, 2));
  // R10
  page_with_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_o |-> cyc_valid_o);
  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind edo_cycle_decoder edo_cycle_decoder_chk #(.LANES(LANES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i),
  .we_n_i(we_n_i), .oe_n_i(oe_n_i), .cyc_valid_o(cyc_valid_o),
  .cyc_type_o(cyc_type_o), .lane_o(lane_o), .page_o(page_o),
  .dout_en_o(dout_en_o), .err_o(err_o)
);

// File: tb/edo_cycle_decoder_bench.sv
`timescale 1ns/1ps
module edo_cycle_decoder_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ras_n_i = 1'b1;
  logic [1:0] cas_n_i = 2'b11;
  logic       we_n_i = 1'b1;
  logic       oe_n_i = 1'b1;
  logic       cyc_valid_o, page_o, err_o;
  logic [2:0] cyc_type_o;
  logic [1:0] lane_o, dout_en_o;

  always #5 clk_i = ~clk_i;

  edo_cycle_decoder #(.LANES(2)) u_edo_cycle_decoder (
    .clk_i, .rst_ni, .ras_n_i, .cas_n_i, .we_n_i, .oe_n_i,
    .cyc_valid_o, .cyc_type_o, .lane_o, .page_o, .dout_en_o, .err_o
  );

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: outputs after edge k depend on inputs seen at k-1 and k-2
  bit h1r = 1, h2r = 1, h1w = 1, h2w = 1, h1o = 1;
  bit [1:0] h1c = 2'b11, h2c = 2'b11;
  bit m_inc, m_cbr, m_seen, m_fe, m_ae, m_wl, m_rd, m_pg, m_err;
  bit [1:0] m_ls, m_la, m_lm, m_dq;
  bit x_v, x_page, x_err;
  int x_type;
  bit [1:0] x_lane, x_dout;

  function automatic int classify();
    if (m_cbr) return 6;
    if (!m_seen) return 5;
    if (m_fe) return 2;
    if (m_wl && m_rd) return 4;
    if (m_wl) return 3;
    if (m_rd) return 1;
    return 7;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {h1r, h2r, h1w, h2w, h1o} = 5'b11111; h1c = 2'b11; h2c = 2'b11;
      {m_inc, m_cbr, m_seen, m_fe, m_ae, m_wl, m_rd, m_pg, m_err} = '0;
      m_ls = 0; m_la = 0; m_lm = 0; m_dq = 0;
      x_v = 0; x_type = 0; x_lane = 0; x_page = 0; x_dout = 0; x_err = 0;
    end else begin
      bit rfall, rrise, clow, afall, eff, rdok, bad;
      bit [1:0] nd, lfall;
      rfall = h2r && !h1r;
      rrise = !h2r && h1r;
      clow  = (h1c != 2'b11);
      afall = (h2c == 2'b11) && clow;
      lfall = h2c & ~h1c;
      eff   = afall ? !h1w : m_ae;
      rdok  = m_inc && !m_cbr && !eff;
      for (int i = 0; i < 2; i++)
        nd[i] = (rdok && !h1r && !h1c[i] && h1w && !h1o) ||
                (m_dq[i] && !h1o && h1w && (!h1r || !h1c[i]));
      x_v = rrise && m_inc;
      x_type = x_v ? classify() : 0;
      x_lane = x_v ? m_ls : 2'b00;
      x_page = x_v && m_pg;
      if (rfall) begin
        m_inc = 1; m_cbr = clow; m_seen = 0; m_fe = 0; m_ae = 0;
        m_wl = 0; m_rd = 0; m_pg = 0; m_ls = 0; m_la = 0;
      end else if (m_inc && !h1r && !m_cbr) begin
        bad = 0;
        for (int i = 0; i < 2; i++)
          if (lfall[i] && !afall && m_la[1-i] && (m_lm[1-i] != !h1w)) bad = 1;
        if (h2w && !h1w && clow && !eff) m_wl = 1;
        if (clow && !h1o && h1w && !eff) m_rd = 1;
        if (afall) begin
          if (m_seen) m_pg = 1; else m_fe = !h1w;
          m_seen = 1; m_ae = !h1w; m_la = lfall;
        end else m_la = m_la | lfall;
        m_ls = m_ls | lfall;
        for (int i = 0; i < 2; i++) if (lfall[i]) m_lm[i] = !h1w;
        if (bad) m_err = 1;
      end else if (m_inc && rrise) begin
        m_inc = 0;
      end
      m_dq = nd; x_dout = nd; x_err = m_err;
      h2r = h1r; h2c = h1c; h2w = h1w;
      h1r = ras_n_i; h1c = cas_n_i; h1w = we_n_i; h1o = oe_n_i;
    end
  end

  bit got; int g_type; bit [1:0] g_lane; bit g_page;

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      chk(cyc_valid_o == x_v, "R2 valid", cyc_valid_o, x_v);
      chk(cyc_type_o == x_type[2:0], "R2 type", cyc_type_o, x_type);
      chk(lane_o == x_lane, "R8 lanes", lane_o, x_lane);
      chk(page_o == x_page, "R10 page", page_o, x_page);
      chk(dout_en_o == x_dout, "R9 dout", dout_en_o, x_dout);
      chk(err_o == x_err, "R11 err", err_o, x_err);
      if (cyc_valid_o) begin
        got = 1; g_type = cyc_type_o; g_lane = lane_o; g_page = page_o;
      end
    end
  end

  task automatic drv(input bit r, input bit [1:0] c, input bit w, input bit o, input int n);
    @(negedge clk_i);
    ras_n_i = r; cas_n_i = c; we_n_i = w; oe_n_i = o;
    repeat (n) @(posedge clk_i);
  endtask

  task automatic finish_cyc(input string tag, input int et, input bit [1:0] el, input bit ep);
    drv(1, 2'b11, 1, 1, 4);
    chk(got, {tag, " pulse seen"}, got, 1);
    chk(g_type == et, {tag, " type"}, g_type, et);
    chk(g_lane == el, {tag, " lanes"}, g_lane, el);
    chk(g_page == ep, {tag, " page"}, g_page, ep);
    got = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(cyc_valid_o == 0 && cyc_type_o == 0 && lane_o == 0 && dout_en_o == 0 &&
        err_o == 0 && page_o == 0, "R1 reset outputs", cyc_type_o, 0);
    rst_ni = 1;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk(cyc_valid_o == 0 && dout_en_o == 0 && err_o == 0, "R1 after release", dout_en_o, 0);

    // R7 word read
    drv(0, 2'b11, 1, 1, 2); drv(0, 2'b00, 1, 1, 1); drv(0, 2'b00, 1, 0, 3);
    @(negedge clk_i); chk(dout_en_o == 2'b11, "R9 read drives", dout_en_o, 3);
    drv(0, 2'b11, 1, 0, 2); drv(0, 2'b11, 1, 1, 1);
    finish_cyc("R7 read", 1, 2'b11, 0);

    // R5 early write, lower lane, output must stay off
    drv(1, 2'b11, 0, 0, 1); drv(0, 2'b11, 0, 0, 2); drv(0, 2'b10, 0, 0, 2);
    drv(0, 2'b10, 1, 0, 2);
    @(negedge clk_i); chk(dout_en_o == 0, "R5 early write no drive", dout_en_o, 0);
    drv(0, 2'b11, 1, 1, 1);
    finish_cyc("R5 early write", 2, 2'b01, 0);

    // R6 delayed write
    drv(0, 2'b11, 1, 1, 2); drv(0, 2'b00, 1, 1, 2); drv(0, 2'b00, 0, 1, 2);
    drv(0, 2'b11, 1, 1, 1);
    finish_cyc("R6 delayed write", 3, 2'b11, 0);

    // R6 read-modify-write, upper lane
    drv(0, 2'b11, 1, 1, 2); drv(0, 2'b01, 1, 0, 3); drv(0, 2'b01, 1, 1, 1);
    drv(0, 2'b01, 0, 1, 2); drv(0, 2'b11, 1, 1, 1);
    finish_cyc("R6 rmw", 4, 2'b10, 0);

    // R4 row-only refresh
    drv(0, 2'b11, 1, 1, 4);
    finish_cyc("R4 row only", 5, 2'b00, 0);

    // R3 column-before-row refresh
    drv(1, 2'b01, 1, 1, 2); drv(0, 2'b01, 1, 1, 3); drv(0, 2'b11, 1, 1, 1);
    finish_cyc("R3 cbr", 6, 2'b00, 0);

    // R7 output-disabled read
    drv(0, 2'b11, 1, 1, 2); drv(0, 2'b00, 1, 1, 3); drv(0, 2'b11, 1, 1, 1);
    finish_cyc("R7 read oe off", 7, 2'b11, 0);

    // R9 hidden refresh: data held across row toggle
    drv(0, 2'b11, 1, 1, 2); drv(0, 2'b00, 1, 0, 3); drv(1, 2'b00, 1, 0, 3);
    chk(got && g_type == 1, "R9 hidden read type", g_type, 1); got = 0;
    drv(0, 2'b00, 1, 0, 3);
    @(negedge clk_i); chk(dout_en_o == 2'b11, "R9 held in refresh", dout_en_o, 3);
    drv(1, 2'b00, 1, 0, 3);
    chk(got && g_type == 6, "R3 hidden refresh type", g_type, 6); got = 0;
    drv(1, 2'b11, 1, 0, 3);
    @(negedge clk_i); chk(dout_en_o == 0, "R9 off after both high", dout_en_o, 0);
    drv(1, 2'b11, 1, 1, 2);

    // R10 page read, three accesses
    drv(0, 2'b11, 1, 0, 2);
    for (int k = 0; k < 3; k++) begin
      drv(0, 2'b00, 1, 0, 2); drv(0, 2'b11, 1, 0, 1);
    end
    drv(0, 2'b11, 1, 1, 1);
    finish_cyc("R10 page read", 1, 2'b11, 1);

    // R12 staggered lanes are one access
    drv(0, 2'b11, 1, 1, 2); drv(0, 2'b10, 1, 0, 1); drv(0, 2'b00, 1, 0, 2);
    drv(0, 2'b11, 1, 1, 1);
    chk(err_o == 0, "R11 no error on legal traffic", err_o, 0);
    finish_cyc("R12 staggered", 1, 2'b11, 0);

    // R11 upper delayed, lower early in one access
    drv(0, 2'b11, 1, 1, 2); drv(0, 2'b01, 1, 1, 2); drv(0, 2'b01, 0, 1, 1);
    drv(0, 2'b00, 0, 1, 3);
    @(negedge clk_i); chk(err_o == 1, "R11 mixed lane modes", err_o, 1);
    drv(0, 2'b11, 1, 1, 1);
    finish_cyc("R11 mixed cycle", 3, 2'b11, 0);
    chk(err_o == 1, "R11 sticky", err_o, 1);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule